// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block drives and samples a large set of general-purpose pins grouped into equal banks. Each bank has its own window on a simple 32-bit register bus. In that window, software sets each pin's direction, its output value, an access mask that protects pins from unintended data writes, and an input gate. The block drives each output pin's pad and its output enable. It samples input pads through a two-flop synchronizer.

Each pin also has an event detector. The detector can watch for a rising edge, a falling edge, either edge, a high level or a low level. A detected edge is latched in a raw status bit until software clears it. A level condition is not latched: the raw bit shows the condition as long as it holds. Raw status is ANDed with a per-pin enable to give masked status. Masked status from every bank is ORed onto one interrupt line for the parent interrupt controller.

The default configuration has 16 banks of 16 pins, 256 pins in all. Pin n sits in bank n/16 at bit n mod 16.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_out` are all zero and `irq_out` is low.
- R2: Bank b's registers sit at byte address b*0x80 plus a word offset: 0x00 data, 0x04 access mask, 0x08 direction, 0x0C sense (1 = level, 0 = edge), 0x10 any-edge select, 0x14 polarity (1 = high/rising, 0 = low/falling), 0x18 interrupt enable, 0x1C raw status (read-only), 0x20 masked status (read-only), 0x24 clear (write-1, reads 0) and 0x28 input gate. Bits 31:16 of every read, and every other offset, read zero.
- R3: A direction bit of 1 drives `pad_oe` high for that pin and puts the pin's data bit on `pad_out`. A direction bit of 0 keeps both low.
- R4: A data write changes only the pins whose access-mask bit is 1. A data read returns 0 for every pin whose mask bit is 0.
- R5: For an input pin with mask 1, a data read returns the pad value two clocks after the pad changes when the input-gate bit is 1, and returns 0 when the gate bit is 0.
- R6: In edge sense with any-edge 0, the raw bit latches on a rising edge when polarity is 1 and on a falling edge when polarity is 0, and it stays set until cleared.
- R7: In edge sense with any-edge 1, both transitions latch the raw bit, whatever the polarity bit holds.
- R8: In level sense the raw bit equals the gated pad level (inverted when polarity is 0) each cycle, so a clear leaves it set while the level holds.
- R9: Masked status reads raw status AND interrupt enable. Writing 1 to a clear bit resets a latched edge bit.
- R10: `irq_out` is high exactly when some masked status bit in some bank is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 11 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | 256 | Pad input values |
| pad_out | output | 256 | Pad output values |
| pad_oe | output | 256 | Pad output enables |
| irq_out | output | 1 | Parent interrupt |

## Verification
The hardest case to reach from the ports is a clear that arrives while a level condition still holds. In that case the raw bit must not drop, and the behaviour differs from a cleared edge only in what the register reads back afterwards. For every bank, the bench uses one pin, a different pin in each bank. It steps that pin through all five sense modes with the same pad sequence: low, high, clear, low, clear, then high again with the enable off. At each step it compares raw, masked and interrupt values against a table computed from the mode. Any-edge runs alternate the polarity bit between banks, to show that polarity is ignored in that mode.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
    localparam int BUS_W      = 32;
    localparam int BANK_BYTES = 128;
    localparam int WORD_W     = 5;

    typedef enum logic [WORD_W-1:0] {
        W_DATA   = 5'd0,
        W_DMASK  = 5'd1,
        W_DIR    = 5'd2,
        W_SENSE  = 5'd3,
        W_ANYEDG = 5'd4,
        W_POL    = 5'd5,
        W_IEN    = 5'd6,
        W_RAW    = 5'd7,
        W_MASKED = 5'd8,
        W_CLEAR  = 5'd9,
        W_INGATE = 5'd10
    } reg_word_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] prev_q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_q,
    input  logic [W-1:0] prev_q,
    input  logic [W-1:0] ingate,
    input  logic [W-1:0] sense,
    input  logic [W-1:0] anyedge,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] clr,
    input  logic         cfg_wr,
    output logic [W-1:0] raw_q
);
    logic [W-1:0] rise, fall, edge_evt, lvl_act, raw_d;

    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            rise[i]    = ingate[i] & sync_q[i] & ~prev_q[i];
            fall[i]    = ingate[i] & ~sync_q[i] & prev_q[i];
            lvl_act[i] = ingate[i] & (pol[i] ? sync_q[i] : ~sync_q[i]);
            if (anyedge[i])
                edge_evt[i] = rise[i] | fall[i];
            else
                edge_evt[i] = pol[i] ? rise[i] : fall[i];
            if (sense[i])
                raw_d[i] = lvl_act[i];
            else
                raw_d[i] = (raw_q[i] & ~clr[i]) | edge_evt[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_d;
    end

    // R6: latched edge bits survive until a clear or reconfiguration
    assert_edge_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ((raw_q & $past(raw_q & ~sense & ~clr)) == $past(raw_q & ~sense & ~clr)));

    // R9: a clear with no coincident event empties the edge bit
    assert_clear_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr != '0) && !cfg_wr) |=> ((raw_q & $past(clr & ~sense & ~edge_evt)) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_ctrl_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] word,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      rd_data,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic              bank_irq
);
    logic [W-1:0] data_q, dmask_q, dir_q, sense_q, anyedge_q, pol_q, ien_q, ingate_q;
    logic [W-1:0] sync_q, prev_q, raw_q, masked, clr_vec, data_view;
    logic         cfg_wr;
    reg_word_e    sel;

    assign sel     = reg_word_e'(word);
    assign cfg_wr  = wr_en && (sel == W_SENSE || sel == W_ANYEDG ||
                               sel == W_POL || sel == W_INGATE);
    assign clr_vec = (wr_en && sel == W_CLEAR) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q    <= '0;
            dmask_q   <= '0;
            dir_q     <= '0;
            sense_q   <= '0;
            anyedge_q <= '0;
            pol_q     <= '0;
            ien_q     <= '0;
            ingate_q  <= '0;
        end else if (wr_en) begin
            unique case (sel)
                W_DATA:   data_q    <= (data_q & ~dmask_q) | (wdata & dmask_q);
                W_DMASK:  dmask_q   <= wdata;
                W_DIR:    dir_q     <= wdata;
                W_SENSE:  sense_q   <= wdata;
                W_ANYEDG: anyedge_q <= wdata;
                W_POL:    pol_q     <= wdata;
                W_IEN:    ien_q     <= wdata;
                W_INGATE: ingate_q  <= wdata;
                default:  ;
            endcase
        end
    end

    gpio_in_sync #(.W(W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .sync_q (sync_q),
        .prev_q (prev_q)
    );

    gpio_evt_detect #(.W(W)) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_q  (sync_q),
        .prev_q  (prev_q),
        .ingate  (ingate_q),
        .sense   (sense_q),
        .anyedge (anyedge_q),
        .pol     (pol_q),
        .clr     (clr_vec),
        .cfg_wr  (cfg_wr),
        .raw_q   (raw_q)
    );

    assign masked    = raw_q & ien_q;
    assign bank_irq  = |masked;
    assign pad_oe    = dir_q;
    assign pad_out   = data_q & dir_q;
    assign data_view = dmask_q & ((dir_q & data_q) | (~dir_q & ingate_q & sync_q));

    always_comb begin
        unique case (sel)
            W_DATA:   rd_data = data_view;
            W_DMASK:  rd_data = dmask_q;
            W_DIR:    rd_data = dir_q;
            W_SENSE:  rd_data = sense_q;
            W_ANYEDG: rd_data = anyedge_q;
            W_POL:    rd_data = pol_q;
            W_IEN:    rd_data = ien_q;
            W_RAW:    rd_data = raw_q;
            W_MASKED: rd_data = masked;
            W_INGATE: rd_data = ingate_q;
            default:  rd_data = '0;
        endcase
    end

    // R4: pins outside the access mask keep their data bit across a data write
    assert_dmask_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == W_DATA) |=> ((data_q & ~$past(dmask_q)) == $past(data_q & ~dmask_q)));

    // R3: a direction write shows up on the pad enables next cycle
    assert_oe_after_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == W_DIR) |=> (pad_oe == $past(wdata)));

    // R10: the bank interrupt needs a latched or active raw bit
    assert_irq_needs_raw_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bank_irq |-> (raw_q != '0));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_ctrl_pkg::*;
#(
    parameter int NUM_BANKS = 16,
    parameter int PINS      = 16,
    parameter int ADDR_W    = $clog2(NUM_BANKS) + 7,
    parameter int NPINS     = NUM_BANKS * PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq_out
);
    localparam int BSEL_W = ADDR_W - 7;

    logic [BSEL_W-1:0] bank_idx;
    logic [WORD_W-1:0] word;
    logic [PINS-1:0]   bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_irq;

    assign bank_idx = reg_addr[ADDR_W-1:7];
    assign word     = reg_addr[6:2];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank #(.W(PINS)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_en && reg_we && (int'(bank_idx) == b)),
            .word     (word),
            .wdata    (reg_wdata[PINS-1:0]),
            .rd_data  (bank_rd[b]),
            .pad_in   (pad_in[b*PINS +: PINS]),
            .pad_out  (pad_out[b*PINS +: PINS]),
            .pad_oe   (pad_oe[b*PINS +: PINS]),
            .bank_irq (bank_irq[b])
        );
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_en && !reg_we && int'(bank_idx) < NUM_BANKS)
            reg_rdata[PINS-1:0] = bank_rd[bank_idx];
    end

    assign irq_out = |bank_irq;

    // R2: the upper half of every read is zero
    assert_rdata_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[BUS_W-1:PINS] == '0);
endmodule

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;
    localparam int NB = 16;
    localparam int NP = 16;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         reg_en = 0, reg_we = 0;
    logic [10:0]  reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [255:0] pad_in = '0;
    logic [255:0] pad_out, pad_oe;
    logic         irq_out;

    int compared = 0, mismatched = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    gpio_bank_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int bank, input int ofs, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1; reg_we = 1; reg_addr = 11'(bank*128 + ofs); reg_wdata = d;
        @(negedge clk);
        reg_en = 0; reg_we = 0;
    endtask

    task automatic rd(input int bank, input int ofs, output logic [31:0] d);
        @(negedge clk);
        reg_en = 1; reg_we = 0; reg_addr = 11'(bank*128 + ofs);
        #1 d = reg_rdata;
        reg_en = 0;
    endtask

    // mode 0 rise, 1 fall, 2 any-edge, 3 high level, 4 low level
    function automatic logic exp_raw(input int mode, input int step);
        case (step)
            0: return mode == 4;
            1: return mode == 0 || mode == 2 || mode == 3;
            2: return mode == 3;
            3: return mode == 1 || mode == 2 || mode == 4;
            4: return mode == 4;
            default: return mode == 0 || mode == 2 || mode == 3;
        endcase
    endfunction

    initial begin
        #100000;
        mismatched++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        chk("R1 oe", 32'(|pad_oe), 0);
        chk("R1 out", 32'(|pad_out), 0);
        chk("R1 irq", 32'(irq_out), 0);
        for (int o = 0; o <= 'h28; o += 4) begin
            rd(7, o, rv); chk("R1 reg", rv, 0);
        end

        // R2/R3 per-bank decode sweep
        for (int b = 0; b < NB; b++) begin
            logic [15:0] pat;
            pat = 16'hA5C3 ^ 16'(b * 16'h0111);
            wr(b, 'h08, {16'hFFFF, pat});
            rd(b, 'h08, rv); chk("R2 dir readback", rv, {16'h0, pat});
            rd(b, 'h2C, rv); chk("R2 unmapped", rv, 0);
            rd(b, 'h24, rv); chk("R2 clear reads 0", rv, 0);
            tick(1);
            chk("R3 oe", 32'(pad_oe[b*NP +: NP]), 32'(pat));
            chk("R3 out zero data", 32'(pad_out[b*NP +: NP]), 0);
        end
        for (int b = 0; b < NB; b++) begin
            rd(b, 'h08, rv);
            chk("R2 no aliasing", rv, 32'(16'hA5C3 ^ 16'(b * 16'h0111)));
            wr(b, 'h08, 0);
        end

        // R4 access mask, R3 output data
        wr(3, 'h08, 32'hFFFF);
        wr(3, 'h04, 32'h00FF);
        wr(3, 'h00, 32'hFFFF);
        rd(3, 'h00, rv); chk("R4 masked read", rv, 32'h00FF);
        tick(1); chk("R3 pad_out", 32'(pad_out[3*NP +: NP]), 32'h00FF);
        wr(3, 'h04, 32'hFFFF);
        wr(3, 'h00, 32'h0000);
        wr(3, 'h04, 32'h0F0F);
        wr(3, 'h00, 32'hFFFF);
        wr(3, 'h04, 32'hFFFF);
        rd(3, 'h00, rv); chk("R4 partial write", rv, 32'h0F0F);
        wr(3, 'h08, 0);
        tick(1); chk("R3 dir0 oe", 32'(pad_oe[3*NP +: NP]), 0);
        chk("R3 dir0 out", 32'(pad_out[3*NP +: NP]), 0);

        // R5 input sampling and gate
        wr(5, 'h04, 32'hFFFF);
        pad_in[5*NP +: NP] = 16'h1234;
        tick(4);
        rd(5, 'h00, rv); chk("R5 gate off", rv, 0);
        wr(5, 'h28, 32'hFFFF);
        rd(5, 'h00, rv); chk("R5 gated read", rv, 32'h1234);
        wr(5, 'h04, 32'h00F0);
        rd(5, 'h00, rv); chk("R4 masked input read", rv, 32'h0030);
        wr(5, 'h28, 0);
        pad_in[5*NP +: NP] = '0;
        tick(4);

        // R6-R10 mode sweep, one pin per bank
        for (int b = 0; b < NB; b++) begin
            for (int m = 0; m < 5; m++) begin
                logic [15:0] bit_p;
                logic        e;
                bit_p = 16'(1) << b;
                wr(b, 'h18, 0);
                wr(b, 'h0C, (m >= 3) ? 32'(bit_p) : 0);
                wr(b, 'h10, (m == 2) ? 32'(bit_p) : 0);
                wr(b, 'h14, (m == 0 || m == 3 || (m == 2 && b[0])) ? 32'(bit_p) : 0);
                wr(b, 'h28, 32'hFFFF);
                pad_in[b*NP + b] = 0;
                tick(4);
                wr(b, 'h24, 32'hFFFF);
                wr(b, 'h18, 32'(bit_p));
                for (int s = 0; s < 6; s++) begin
                    case (s)
                        1: begin pad_in[b*NP + b] = 1; tick(4); end
                        2: wr(b, 'h24, 32'(bit_p));
                        3: begin pad_in[b*NP + b] = 0; tick(4); end
                        4: wr(b, 'h24, 32'(bit_p));
                        5: begin wr(b, 'h18, 0); pad_in[b*NP + b] = 1; tick(4); end
                        default: ;
                    endcase
                    e = exp_raw(m, s);
                    // R6 R7 R8 raw status per mode
                    rd(b, 'h1C, rv);
                    chk(m < 2 ? "R6 raw" : (m == 2 ? "R7 raw" : "R8 raw"), rv, e ? 32'(bit_p) : 0);
                    rd(b, 'h20, rv);
                    chk("R9 masked", rv, (e && s != 5) ? 32'(bit_p) : 0);
                    chk("R10 irq", 32'(irq_out), 32'(e && s != 5));
                end
                wr(b, 'h0C, 0);
                wr(b, 'h10, 0);
                pad_in[b*NP + b] = 0;
                tick(4);
                wr(b, 'h24, 32'hFFFF);
                wr(b, 'h28, 0);
            end
        end
        chk("R10 quiet", 32'(irq_out), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule